// File: doc/BRIEF.md
# Type-A Tag Command Handler

This block is the command layer of a contactless type-A card that carries a seven-byte identifier and a small byte-addressed store. A receive decoder delivers each frame as a byte vector plus a byte count. The block answers with a response frame for the transmitter: a byte vector, a byte count, and a flag that marks a four-bit short frame. It tracks the card life cycle: idle, ready, active, and a halted variant of idle. It covers request and wake-up, two cascade levels of anticollision and select, page reads, checked writes and halt. CRC_A and the block check character are generated and checked inside the block.

Frames arrive as single-cycle pulses. The answer is registered on the same clock edge that takes the frame in, so it is present during the cycle that follows. A run of empty receptions ends the session. The block then reports this and returns to a fresh idle state.

Top module: `tagcmd_fsm`

## Requirements
- R1: In idle, a one-byte frame 0x26 (request) or 0x52 (wake-up) is answered with the two bytes 0x44 0x00 and moves the card to ready. The halted flag is kept. A frame of a different length holding the same byte gets no answer.
- R2: In ready, the frame 0x93 0x20 is answered with five bytes: 0x88, identifier bytes 0 to 2, and the XOR of those four bytes. The frame 0x95 0x20 is answered with identifier bytes 3 to 6 and their XOR.
- R3: In ready, 0x93 0x70 is answered with 0x04 plus CRC, and the state stays ready. 0x95 0x70 is answered with 0x00 plus CRC, and the state becomes active.
- R4: In ready, any other reception, including an empty one, gets no answer. The same holds for any other non-empty frame in active. Either case returns the card to idle, or to halted if the halted flag is set.
- R5: In active, 0x30 followed by page N is answered with 18 bytes: the 16 store bytes from byte address 4N upward, then the CRC. Addresses at or past the store size read as zero.
- R6: In active, 0xA2, page N, four data bytes and a CRC over frame bytes 0 to 5 (in bytes 6 and 7) stores the data at 4N upward when the CRC matches. Addresses past the store are skipped. The answer is the 4-bit short frame 0x0A.
- R7: A write whose CRC does not match leaves the store unchanged and is answered with the short frame 0x01.
- R8: In active, the frame 0x50 0x00 with a valid CRC sets the halted flag and returns to idle, with no answer.
- R9: While halted, only 0x52 is accepted and 0x26 gets no answer. In idle, any frame other than those of R1 gets no answer.
- R10: The eighth empty reception in a row pulses the session-end output for one cycle, with no answer. The card then returns to idle with the halted flag cleared. A non-empty frame restarts the run.
- R11: After reset no answer or session end is signalled. The CRC starts at 0x6363 and uses the reflected polynomial 0x8408 over the bytes in order, and is sent low byte first. Frame byte i sits at bits 8i+7:8i of the data vectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid_i | input | 1 | One-cycle pulse: a reception is complete |
| rx_len_i | input | 4 | Number of received bytes (0 to 8) |
| rx_data_i | input | 64 | Received bytes, byte i at bits 8i+7:8i |
| tx_valid_o | output | 1 | One-cycle pulse: a response is ready |
| tx_len_o | output | 5 | Number of response bytes |
| tx_short_o | output | 1 | Response is a 4-bit short frame without parity or CRC |
| tx_data_o | output | 144 | Response bytes, byte i at bits 8i+7:8i |
| session_end_o | output | 1 | One-cycle pulse: empty-reception limit reached |

## Verification
Every answer, silent or not, is due in the single cycle after the edge that captured the frame. The session-end pulse and any store update are due at that same edge. The driver queues one expectation per frame, including an explicit "no answer" entry. The monitor then compares the outputs on the falling edge after capture and flags any response seen in a cycle where none was queued. Store contents, and states that produce no answer, are brought out by later reads and requests through the same frame interface.

// File: rtl/tagcmd_pkg.sv
package tagcmd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_READY  = 2'd1,
    ST_ACTIVE = 2'd2
  } tag_state_e;

  localparam logic [15:0] CRC_SEED    = 16'h6363;
  localparam logic [7:0]  CMD_REQ     = 8'h26;
  localparam logic [7:0]  CMD_WAKE    = 8'h52;
  localparam logic [7:0]  CMD_CL1     = 8'h93;
  localparam logic [7:0]  CMD_CL2     = 8'h95;
  localparam logic [7:0]  NVB_ALL     = 8'h20;
  localparam logic [7:0]  NVB_FULL    = 8'h70;
  localparam logic [7:0]  CMD_RD      = 8'h30;
  localparam logic [7:0]  CMD_WR      = 8'hA2;
  localparam logic [7:0]  CMD_HALT    = 8'h50;
  localparam logic [7:0]  CASCADE_TAG = 8'h88;
  localparam logic [7:0]  REPLY_ACK   = 8'h0A;
  localparam logic [7:0]  REPLY_NAK   = 8'h01;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] b);
    logic [7:0] t;
    t = b ^ c[7:0];
    t = t ^ {t[3:0], 4'b0000};
    return {8'h00, c[15:8]} ^ {t, 8'h00} ^ {5'b00000, t, 3'b000} ^ {12'h000, t[7:4]};
  endfunction
endpackage

// File: rtl/tagcmd_crc.sv
module tagcmd_crc
  import tagcmd_pkg::*;
#(
  parameter int NBYTES = 2
) (
  input  logic [8*NBYTES-1:0] data_i,
  output logic [15:0]         crc_o
);
  logic [15:0] chain [NBYTES+1];

  assign chain[0] = CRC_SEED;
  for (genvar i = 0; i < NBYTES; i++) begin : g_step
    assign chain[i+1] = crc_step(chain[i], data_i[8*i +: 8]);
  end
  assign crc_o = chain[NBYTES];
endmodule

// File: rtl/tagcmd_store.sv
module tagcmd_store #(
  parameter int MEM_BYTES = 64,
  parameter int AW        = 11,
  parameter int RD_BYTES  = 16,
  parameter int WR_BYTES  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we_i,
  input  logic [AW-1:0]         wbase_i,
  input  logic [8*WR_BYTES-1:0] wdata_i,
  input  logic [AW-1:0]         rbase_i,
  output logic [8*RD_BYTES-1:0] rdata_o
);
  localparam int SW = 8 * MEM_BYTES;

  logic [SW-1:0] store_q;
  logic [SW-1:0] store_d;

  always_comb begin
    store_d = store_q;
    for (int k = 0; k < WR_BYTES; k++) begin
      if (int'(wbase_i) + k < MEM_BYTES)
        store_d[8*(int'(wbase_i) + k) +: 8] = wdata_i[8*k +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    store_q <= '0;
    else if (we_i) store_q <= store_d;
  end

  for (genvar j = 0; j < RD_BYTES; j++) begin : g_rd
    logic [AW-1:0] ra;
    assign ra = rbase_i + AW'(j);
    assign rdata_o[8*j +: 8] = (int'(ra) < MEM_BYTES) ? store_q[{ra, 3'b000} +: 8] : 8'h00;
  end
endmodule

// File: rtl/tagcmd_fsm.sv
module tagcmd_fsm
  import tagcmd_pkg::*;
#(
  parameter int          MEM_BYTES   = 64,
  parameter int          EMPTY_LIMIT = 8,
  parameter logic [55:0] UID         = 56'hB6217E935A1C04
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rx_valid_i,
  input  logic [3:0]   rx_len_i,
  input  logic [63:0]  rx_data_i,
  output logic         tx_valid_o,
  output logic [4:0]   tx_len_o,
  output logic         tx_short_o,
  output logic [143:0] tx_data_o,
  output logic         session_end_o
);
  localparam int RX_BYTES = 8;
  localparam int TX_BYTES = 18;
  localparam int PAGE_B   = 4;
  localparam int RD_BYTES = 16;
  localparam int AW       = 8 + $clog2(PAGE_B) + 1;
  localparam int CW       = $clog2(EMPTY_LIMIT);

  logic [7:0] rb [RX_BYTES];
  logic [7:0] ub [7];
  for (genvar g = 0; g < RX_BYTES; g++) begin : g_rxb
    assign rb[g] = rx_data_i[8*g +: 8];
  end
  for (genvar g = 0; g < 7; g++) begin : g_uid
    assign ub[g] = UID[8*g +: 8];
  end

  tag_state_e        st_q, st_d;
  logic              halted_q, halted_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              tx_valid_d, tx_short_d, end_d;
  logic [4:0]        tx_len_d;
  logic [8*TX_BYTES-1:0] tx_data_d;

  logic [AW-1:0]     page_base;
  logic [8*RD_BYTES-1:0] rd_bytes;
  logic [15:0]       crc_rd, crc_wr, crc_halt, crc_sak;
  logic [7:0]        sak;
  logic              mem_we, wr_ok, is_one;

  assign page_base = {1'b0, rb[1], 2'b00};
  assign sak       = (rb[0] == CMD_CL2) ? 8'h00 : 8'h04;
  assign is_one    = (rx_len_i == 4'd1);

  tagcmd_store #(.MEM_BYTES(MEM_BYTES), .AW(AW), .RD_BYTES(RD_BYTES), .WR_BYTES(PAGE_B)) u_store (
    .clk(clk), .rst_n(rst_n), .we_i(mem_we), .wbase_i(page_base),
    .wdata_i(rx_data_i[47:16]), .rbase_i(page_base), .rdata_o(rd_bytes));

  tagcmd_crc #(.NBYTES(RD_BYTES)) u_crc_rd   (.data_i(rd_bytes),         .crc_o(crc_rd));
  tagcmd_crc #(.NBYTES(6))        u_crc_wr   (.data_i(rx_data_i[47:0]),  .crc_o(crc_wr));
  tagcmd_crc #(.NBYTES(2))        u_crc_halt (.data_i(rx_data_i[15:0]),  .crc_o(crc_halt));
  tagcmd_crc #(.NBYTES(1))        u_crc_sak  (.data_i(sak),              .crc_o(crc_sak));

  assign wr_ok = ({rb[7], rb[6]} == crc_wr);

  always_comb begin
    st_d       = st_q;
    halted_d   = halted_q;
    cnt_d      = cnt_q;
    tx_valid_d = 1'b0;
    tx_len_d   = '0;
    tx_short_d = 1'b0;
    tx_data_d  = '0;
    end_d      = 1'b0;
    mem_we     = 1'b0;
    if (rx_valid_i) begin
      unique case (st_q)
        ST_IDLE: begin
          if (is_one && (rb[0] == CMD_WAKE || (rb[0] == CMD_REQ && !halted_q))) begin
            tx_valid_d = 1'b1;
            tx_len_d   = 5'd2;
            tx_data_d[15:0] = 16'h0044;
            st_d       = ST_READY;
          end
        end
        ST_READY: begin
          if (rb[0] == CMD_CL1 && rb[1] == NVB_ALL) begin
            tx_valid_d = 1'b1;
            tx_len_d   = 5'd5;
            tx_data_d[39:0] = {CASCADE_TAG ^ ub[0] ^ ub[1] ^ ub[2], ub[2], ub[1], ub[0], CASCADE_TAG};
          end else if (rb[0] == CMD_CL2 && rb[1] == NVB_ALL) begin
            tx_valid_d = 1'b1;
            tx_len_d   = 5'd5;
            tx_data_d[39:0] = {ub[3] ^ ub[4] ^ ub[5] ^ ub[6], ub[6], ub[5], ub[4], ub[3]};
          end else if ((rb[0] == CMD_CL1 || rb[0] == CMD_CL2) && rb[1] == NVB_FULL) begin
            tx_valid_d = 1'b1;
            tx_len_d   = 5'd3;
            tx_data_d[23:0] = {crc_sak, sak};
            if (rb[0] == CMD_CL2) st_d = ST_ACTIVE;
          end else begin
            st_d = ST_IDLE;
          end
        end
        ST_ACTIVE: begin
          if (rx_len_i != '0) begin
            if (rb[0] == CMD_RD) begin
              tx_valid_d = 1'b1;
              tx_len_d   = 5'(TX_BYTES);
              tx_data_d  = {crc_rd, rd_bytes};
            end else if (rb[0] == CMD_WR) begin
              tx_valid_d = 1'b1;
              tx_len_d   = 5'd1;
              tx_short_d = 1'b1;
              tx_data_d[7:0] = wr_ok ? REPLY_ACK : REPLY_NAK;
              mem_we     = wr_ok;
            end else if (rb[0] == CMD_HALT && rb[1] == 8'h00 && {rb[3], rb[2]} == crc_halt) begin
              st_d     = ST_IDLE;
              halted_d = 1'b1;
            end else begin
              st_d = ST_IDLE;
            end
          end
        end
        default: st_d = ST_IDLE;
      endcase
      if (rx_len_i == '0) begin
        if (cnt_q == CW'(EMPTY_LIMIT - 1)) begin
          cnt_d    = '0;
          end_d    = 1'b1;
          st_d     = ST_IDLE;
          halted_d = 1'b0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else begin
        cnt_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q          <= ST_IDLE;
      halted_q      <= 1'b0;
      cnt_q         <= '0;
      tx_valid_o    <= 1'b0;
      tx_len_o      <= '0;
      tx_short_o    <= 1'b0;
      tx_data_o     <= '0;
      session_end_o <= 1'b0;
    end else begin
      st_q          <= st_d;
      halted_q      <= halted_d;
      cnt_q         <= cnt_d;
      tx_valid_o    <= tx_valid_d;
      tx_len_o      <= tx_len_d;
      tx_short_o    <= tx_short_d;
      tx_data_o     <= tx_data_d;
      session_end_o <= end_d;
    end
  end

  // R3
  active_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q == ST_ACTIVE) |-> $past(st_q) == ST_READY);
  // R8
  halt_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted_q) |-> $past(st_q) == ST_ACTIVE);
  // R6
  write_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> tx_valid_o && tx_short_o && tx_data_o[7:0] == REPLY_ACK);
  // R10
  session_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    session_end_o |-> $past(rx_valid_i && rx_len_i == '0) && st_q == ST_IDLE && !halted_q && !tx_valid_o);
  // R11
  tx_follows_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_o |-> $past(rx_valid_i));
endmodule

// File: tb/tagcmd_fsm_tb.sv
module tagcmd_fsm_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         rx_valid;
  logic [3:0]   rx_len;
  logic [63:0]  rx_data;
  logic         tx_valid, tx_short, session_end;
  logic [4:0]   tx_len;
  logic [143:0] tx_data;

  always #4 clk = ~clk;

  tagcmd_fsm #(.MEM_BYTES(64), .EMPTY_LIMIT(8), .UID(56'hB6217E935A1C04)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_valid_i(rx_valid), .rx_len_i(rx_len), .rx_data_i(rx_data),
    .tx_valid_o(tx_valid), .tx_len_o(tx_len), .tx_short_o(tx_short), .tx_data_o(tx_data),
    .session_end_o(session_end));

  typedef struct {
    logic         v;
    logic [4:0]   len;
    logic         sh;
    logic [143:0] dat;
    logic         ep;
    string        tag;
  } exp_t;

  localparam logic [7:0] UIDB [7] = '{8'h04, 8'h1C, 8'h5A, 8'h93, 8'h7E, 8'h21, 8'hB6};

  exp_t       q[$];
  int         n_chk = 0;
  int         n_bad = 0;
  logic       sent;
  logic [7:0] mdl [64];
  logic [7:0] bb [18];

  function automatic logic [15:0] bcrc(input int n);
    logic [15:0] c;
    c = 16'h6363;
    for (int i = 0; i < n; i++) begin
      c = c ^ {8'h00, bb[i]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 16'h8408) : (c >> 1);
    end
    return c;
  endfunction

  function automatic logic [143:0] pack(input int n);
    logic [143:0] d;
    d = '0;
    for (int i = 0; i < n; i++) d[8*i +: 8] = bb[i];
    return d;
  endfunction

  function automatic exp_t none(input string t, input logic ep = 1'b0);
    exp_t e;
    e.v = 1'b0; e.len = '0; e.sh = 1'b0; e.dat = '0; e.ep = ep; e.tag = t;
    return e;
  endfunction

  function automatic exp_t rsp(input string t, input int n, input logic [143:0] d, input logic sh);
    exp_t e;
    e.v = 1'b1; e.len = 5'(n); e.sh = sh; e.dat = d; e.ep = 1'b0; e.tag = t;
    return e;
  endfunction

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
  endtask

  always @(posedge clk) sent <= rx_valid;

  always @(negedge clk) begin
    if (sent === 1'b1) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if (tx_valid !== e.v || session_end !== e.ep ||
          (e.v && (tx_len !== e.len || tx_short !== e.sh || tx_data !== e.dat))) begin
        n_bad++;
        $display("FAIL %s: got v=%0b len=%0d sh=%0b end=%0b data=%h expected v=%0b len=%0d sh=%0b end=%0b data=%h",
                 e.tag, tx_valid, tx_len, tx_short, session_end, tx_data, e.v, e.len, e.sh, e.ep, e.dat);
      end
    end else if (rst_n && (tx_valid === 1'b1 || session_end === 1'b1)) begin
      n_chk++;
      n_bad++;
      $display("FAIL R11 unsolicited output: got v=%0b end=%0b expected 0 0", tx_valid, session_end);
    end
  end

  task automatic xfer(input logic [63:0] d, input int n, input exp_t e);
    @(negedge clk);
    rx_data  = d;
    rx_len   = 4'(n);
    rx_valid = 1'b1;
    q.push_back(e);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic anticoll(input int lvl, input string t);
    if (lvl == 1) begin
      bb[0] = 8'h88; bb[1] = UIDB[0]; bb[2] = UIDB[1]; bb[3] = UIDB[2];
    end else begin
      bb[0] = UIDB[3]; bb[1] = UIDB[4]; bb[2] = UIDB[5]; bb[3] = UIDB[6];
    end
    bb[4] = bb[0] ^ bb[1] ^ bb[2] ^ bb[3];
    xfer((lvl == 1) ? 64'h2093 : 64'h2095, 2, rsp(t, 5, pack(5), 1'b0));
  endtask

  task automatic sel(input int lvl, input string t);
    logic [15:0] c;
    bb[0] = (lvl == 1) ? 8'h04 : 8'h00;
    c = bcrc(1);
    bb[1] = c[7:0]; bb[2] = c[15:8];
    xfer((lvl == 1) ? 64'h7093 : 64'h7095, 2, rsp(t, 3, pack(3), 1'b0));
  endtask

  task automatic do_write(input int page, input logic [31:0] dw, input bit good, input string t);
    logic [15:0] c;
    bb[0] = 8'hA2; bb[1] = 8'(page);
    for (int k = 0; k < 4; k++) bb[2+k] = dw[8*k +: 8];
    c = bcrc(6);
    if (!good) c = c ^ 16'h0100;
    if (good) for (int k = 0; k < 4; k++) if (page*4 + k < 64) mdl[page*4 + k] = dw[8*k +: 8];
    xfer({c, dw, 8'(page), 8'hA2}, 8, rsp(t, 1, good ? 144'h0A : 144'h01, 1'b1));
  endtask

  task automatic do_read(input int page, input string t);
    logic [15:0] c;
    for (int i = 0; i < 16; i++) bb[i] = (page*4 + i < 64) ? mdl[page*4 + i] : 8'h00;
    c = bcrc(16);
    bb[16] = c[7:0]; bb[17] = c[15:8];
    xfer({48'h0, 8'(page), 8'h30}, 2, rsp(t, 18, pack(18), 1'b0));
  endtask

  task automatic to_active(input logic [7:0] opener);
    xfer({56'h0, opener}, 1, rsp("R1 request/wake-up", 2, 144'h0044, 1'b0));
    anticoll(1, "R2 cascade level 1");
    anticoll(2, "R2 cascade level 2");
    sel(1, "R3 select level 1 SAK 0x04");
    sel(2, "R3 select level 2 SAK 0x00");
  endtask

  initial begin
    logic [15:0] hc;
    rx_valid = 1'b0; rx_len = '0; rx_data = '0;
    for (int i = 0; i < 64; i++) mdl[i] = 8'h00;
    repeat (3) @(negedge clk);
    n_chk++;
    if (tx_valid !== 1'b0 || session_end !== 1'b0) begin
      n_bad++;
      $display("FAIL R11 reset: got v=%0b end=%0b expected 0 0", tx_valid, session_end);
    end
    rst_n = 1'b1;
    xfer(64'h0030, 2, none("R9 read ignored in idle"));
    xfer(64'h0026, 2, none("R1 two-byte request ignored"));
    to_active(8'h26);
    do_write(1, 32'hEFBEADDE, 1'b1, "R6 good write page 1");
    do_write(2, 32'h44332211, 1'b0, "R7 bad CRC write page 2");
    do_read(0, "R5 read page 0 shows R6 store and R7 no store");
    do_write(15, 32'hD4C3B2A1, 1'b1, "R6 write last page");
    do_write(16, 32'h99887766, 1'b1, "R6 write past end acked");
    do_read(14, "R5 read straddling end of store");
    do_read(16, "R5 read past end is zero");
    bb[0] = 8'h50; bb[1] = 8'h00;
    hc = bcrc(2);
    xfer({32'h0, hc, 16'h0050}, 4, none("R8 halt no answer"));
    xfer(64'h26, 1, none("R9 request ignored while halted"));
    xfer(64'h52, 1, rsp("R1 wake-up from halt", 2, 144'h0044, 1'b0));
    xfer(64'h77, 1, none("R4 junk in ready"));
    xfer(64'h26, 1, none("R4 back to halted after junk"));
    for (int i = 0; i < 4; i++) xfer(64'h0, 0, none("R10 empty run"));
    xfer(64'h26, 1, none("R10 non-empty frame restarts run"));
    for (int i = 0; i < 7; i++) xfer(64'h0, 0, none("R10 empty below limit"));
    xfer(64'h0, 0, none("R10 eighth empty ends session", 1'b1));
    to_active(8'h26);
    xfer(64'h60, 1, none("R4 junk in active"));
    xfer(64'h0030, 2, none("R4 read ignored after leaving active"));
    xfer(64'h26, 1, rsp("R4 idle not halted after junk", 2, 144'h0044, 1'b0));
    repeat (4) @(negedge clk);
    summary();
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL R11 watchdog: got timeout expected completion");
    summary();
    $finish;
  end
endmodule